// File: doc/BRIEF.md
# Scratchpad-Delivered Fetch-and-Add Engine

This block accepts single 64-bit command words, each asking for an atomic fetch-and-add on a small internal array of counters. The block does not return the old counter value to the requester. It writes that value as a 64-bit result word into a local scratchpad slot that the command names. Operands can be 8, 16, 32 or 64 bits wide. They are packed little-endian into the 64-bit words of the counter array.

A command can ask to wait for an outside tag switch to finish before it does its add. If a switch is pending when such a command is accepted, the engine stops taking new commands. It does the add when the done pulse arrives. If the done pulse does not arrive within a programmable number of cycles, the engine gives up, leaves the counter as it was, and writes a result word that has its top bit set. Results leave in the order the commands were accepted, with one scratchpad write per command.

Top module: `scratch_fetch_add`

## Requirements
- R1: After reset every counter byte is zero, `sp_we` is low and `cmd_ready` is high.
- R2: The command word is laid out as follows. Bits 63:56 are the scratchpad slot, given as an 8-byte word index. Bits 35:14 are a signed 22-bit increment. Bit 13 is the tag-wait flag. Bits 12:11 are the operand size, where 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits. Bits 10:0 are the counter byte offset. The offset is taken modulo the array size (64 bytes by default). Offset bits below the operand's natural alignment are ignored.
- R3: Take a command accepted with tag-wait clear. In the next cycle `sp_we` is high for exactly one cycle, and `sp_slot` equals the command's slot. Bit 63 of `sp_data` is 0, and bits 62:0 hold the counter's value before the update, sign-extended from the operand width. The counter becomes old value plus the sign-extended increment, modulo the operand width.
- R4: Byte k of a 64-bit counter word sits at bits 8k+7:8k, so operands are little-endian. An add changes only the bytes of its own operand. Every other byte of the array keeps its value.
- R5: A tag-wait command accepted while `tsw_pending` is low behaves exactly like a command with tag-wait clear.
- R6: Take a tag-wait command accepted while `tsw_pending` is high. From the next cycle, `cmd_ready` stays low and no result is written. In the first stalled cycle where `tsw_done` is high, the add is performed. Its success result is written in the following cycle, and `cmd_ready` returns high in that same cycle.
- R7: If `tsw_done` is not seen in any of the first `wait_limit` stalled cycles, the engine writes a result in the cycle after the last of them. A limit of 0 acts as 1. That result has bit 63 set and bits 62:0 zero. The counter is left unchanged and `cmd_ready` returns high.
- R8: Commands accepted on back-to-back cycles each produce one result, one cycle after acceptance and in acceptance order. Each one sees the updates of the commands before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_word | input | 64 | Command word |
| tsw_pending | input | 1 | A tag switch is in progress |
| tsw_done | input | 1 | Pulse: the pending tag switch completed |
| wait_limit | input | TMO_W | Stalled cycles allowed before timeout |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_slot | output | 8 | Scratchpad 8-byte word index |
| sp_data | output | 64 | Result word |

## Verification
Every result is due exactly one cycle after the cycle that causes it:
- For a plain command, that cycle is the acceptance cycle.
- For a stalled command, it is the cycle in which `tsw_done` is seen.
- For a timeout, it is stalled cycle number `wait_limit`.

The bench drives inputs on the falling edge. On the falling edge after the causing rising edge, it checks that `sp_we`, `sp_slot` and `sp_data` hold the expected values. During a stall it checks, at every falling edge, that no write has appeared early. Counter contents are read back through zero-increment commands, which shows that untouched bytes and timed-out counters kept their values.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int CMD_W      = 64;
    localparam int SLOT_W     = 8;
    localparam int INC_W      = 22;
    localparam int OFF_W      = 11;

    // field positions a command producer encodes
    localparam int SLOT_LSB   = 56;
    localparam int INC_LSB    = 14;
    localparam int TWAIT_BIT  = 13;
    localparam int SIZE_LSB   = 11;
    localparam int OFF_LSB    = 0;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } opsize_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [INC_W-1:0]  inc;
        logic              tagwait;
        opsize_e           size;
        logic [OFF_W-1:0]  off;
    } sfa_cmd_t;

    localparam logic [CMD_W-1:0] FAIL_WORD = {1'b1, {(CMD_W-1){1'b0}}};

endpackage

// File: rtl/sfa_decode.sv
module sfa_decode
    import sfa_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    output sfa_cmd_t         fields_o
);
    logic unused_len_pad;

    always_comb begin
        fields_o.slot    = cmd_i[SLOT_LSB +: SLOT_W];
        fields_o.inc     = cmd_i[INC_LSB +: INC_W];
        fields_o.tagwait = cmd_i[TWAIT_BIT];
        fields_o.size    = opsize_e'(cmd_i[SIZE_LSB +: 2]);
        fields_o.off     = cmd_i[OFF_LSB +: OFF_W];
    end

    // length and pad bits carry no meaning for a single-result command
    assign unused_len_pad = ^cmd_i[SLOT_LSB-1:INC_LSB+INC_W];

endmodule

// File: rtl/sfa_alu.sv
module sfa_alu
    import sfa_pkg::*;
(
    input  logic [63:0]      word_i,
    input  logic [2:0]       lane_i,
    input  opsize_e          size_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [63:0]      word_o,
    output logic [62:0]      old_o
);
    localparam int NSZ = 4;

    logic [63:0] field;
    logic [63:0] sext [NSZ];
    logic [63:0] sx_sel;
    logic [63:0] wmask;
    logic [2:0]  lane_al;
    logic [5:0]  shamt;
    logic [63:0] inc64;
    logic [63:0] sum;
    logic        unused_sx_top;

    // one sign-extension variant per operand width
    generate
        for (genvar s = 0; s < NSZ; s++) begin : g_sx
            localparam int W = 8 << s;
            if (W == 64) begin : g_full
                assign sext[s] = field;
            end else begin : g_part
                assign sext[s] = {{(64-W){field[W-1]}}, field[W-1:0]};
            end
        end
    endgenerate

    always_comb begin
        case (size_i)
            SZ_B8:   begin lane_al = lane_i;                wmask = 64'h0000_0000_0000_00FF; end
            SZ_B16:  begin lane_al = {lane_i[2:1], 1'b0};   wmask = 64'h0000_0000_0000_FFFF; end
            SZ_B32:  begin lane_al = {lane_i[2], 2'b00};    wmask = 64'h0000_0000_FFFF_FFFF; end
            default: begin lane_al = 3'd0;                  wmask = 64'hFFFF_FFFF_FFFF_FFFF; end
        endcase
        shamt  = {lane_al, 3'b000};
        field  = (word_i >> shamt) & wmask;
        inc64  = {{(64-INC_W){inc_i[INC_W-1]}}, inc_i};
        sum    = (field + inc64) & wmask;
        word_o = (word_i & ~(wmask << shamt)) | (sum << shamt);
        sx_sel = sext[size_i];
        old_o  = sx_sel[62:0];
    end

    assign unused_sx_top = sx_sel[63];

endmodule

// File: rtl/sfa_wait_ctl.sv
module sfa_wait_ctl #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             done_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             busy_o,
    output logic             fire_ok_o,
    output logic             fire_tmo_o
);
    typedef struct packed {
        logic             busy;
        logic [TMO_W-1:0] cnt;
    } wst_t;

    wst_t st_d, st_q;
    logic [TMO_W:0] elapsed;

    always_comb begin
        st_d       = st_q;
        elapsed    = {1'b0, st_q.cnt} + 1'b1;
        fire_ok_o  = st_q.busy && done_i;
        fire_tmo_o = st_q.busy && !done_i && (elapsed >= {1'b0, limit_i});
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (fire_ok_o || fire_tmo_o) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/scratch_fetch_add.sv
module scratch_fetch_add
    import sfa_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    parameter int TMO_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [63:0]       cmd_word,
    input  logic              tsw_pending,
    input  logic              tsw_done,
    input  logic [TMO_W-1:0]  wait_limit,
    output logic              sp_we,
    output logic [7:0]        sp_slot,
    output logic [63:0]       sp_data
);
    localparam int WORDS = MEM_BYTES / 8;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    typedef struct packed {
        logic              we;
        logic [SLOT_W-1:0] slot;
        logic [63:0]       data;
        sfa_cmd_t          held;
    } top_st_t;

    top_st_t     st_d, st_q;
    logic [63:0] mem_d [WORDS];
    logic [63:0] mem_q [WORDS];

    sfa_cmd_t    dec;
    sfa_cmd_t    op;
    logic        busy, fire_ok, fire_tmo;
    logic        accept, need_wait, exec;
    logic [IDX_W-1:0] widx;
    logic [63:0] alu_new;
    logic [62:0] alu_old;
    logic        unused_off;

    sfa_decode u_dec (
        .cmd_i    (cmd_word),
        .fields_o (dec)
    );

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign need_wait = accept && dec.tagwait && tsw_pending;
    assign op        = busy ? st_q.held : dec;
    assign exec      = (accept && !need_wait) || fire_ok;
    assign widx      = op.off[IDX_W+2:3];
    assign unused_off = ^op.off;

    sfa_wait_ctl #(.TMO_W(TMO_W)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (need_wait),
        .done_i     (tsw_done),
        .limit_i    (wait_limit),
        .busy_o     (busy),
        .fire_ok_o  (fire_ok),
        .fire_tmo_o (fire_tmo)
    );

    sfa_alu u_alu (
        .word_i (mem_q[widx]),
        .lane_i (op.off[2:0]),
        .size_i (op.size),
        .inc_i  (op.inc),
        .word_o (alu_new),
        .old_o  (alu_old)
    );

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (need_wait) st_d.held = dec;
        st_d.we   = exec || fire_tmo;
        st_d.slot = op.slot;
        st_d.data = fire_tmo ? FAIL_WORD : {1'b0, alu_old};
        if (exec) mem_d[widx] = alu_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign sp_we   = st_q.we;
    assign sp_slot = st_q.slot;
    assign sp_data = st_q.data;

endmodule

// File: rtl/sfa_checker.sv
module sfa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [63:0] cmd_word,
    input logic        tsw_pending,
    input logic        tsw_done,
    input logic        sp_we,
    input logic [7:0]  sp_slot,
    input logic [63:0] sp_data
);
    AST_IMMEDIATE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !(cmd_word[13] && tsw_pending)
        |=> sp_we && sp_slot == $past(cmd_word[63:56]) && !sp_data[63]); // R3

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_word[13] && tsw_pending
        |=> !cmd_ready && !sp_we); // R6

    AST_DONE_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready && tsw_done |=> sp_we && !sp_data[63] && cmd_ready); // R6

    AST_TIMEOUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we && sp_data[63] |-> sp_data[62:0] == 63'd0 && $past(!cmd_ready) && cmd_ready); // R7

    AST_WRITE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> $past(cmd_valid && cmd_ready) || $past(!cmd_ready)); // R8
endmodule

bind scratch_fetch_add sfa_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_word    (cmd_word),
    .tsw_pending (tsw_pending),
    .tsw_done    (tsw_done),
    .sp_we       (sp_we),
    .sp_slot     (sp_slot),
    .sp_data     (sp_data)
);

// File: tb/scratch_fetch_add_test.sv
module scratch_fetch_add_test;
    localparam int MEMB = 64;
    localparam int TW   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [63:0]   cmd_word = '0;
    logic          tsw_pending = 1'b0;
    logic          tsw_done = 1'b0;
    logic [TW-1:0] wait_limit = 16'd5;
    logic          sp_we;
    logic [7:0]    sp_slot;
    logic [63:0]   sp_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mb [MEMB];

    always #5 clk = ~clk;

    scratch_fetch_add #(.MEM_BYTES(MEMB), .TMO_W(TW)) uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mkcmd(input logic [7:0] slot, input int inc,
                                          input logic tw, input logic [1:0] sz,
                                          input logic [10:0] off);
        logic [21:0] i22 = inc[21:0];
        return {slot, 8'd1, 12'd0, i22, tw, sz, off};
    endfunction

    // byte-array reference: returns the expected success word, applies the add
    task automatic model_op(input logic [1:0] sz, input logic [10:0] off, input int inc,
                            output logic [63:0] res);
        int n = 1 << sz;
        int base = (int'(off) % MEMB) & ~(n - 1);
        logic [63:0] old = '0;
        logic [63:0] sx;
        logic [63:0] i64 = 64'(signed'(inc));
        logic [63:0] sum;
        for (int i = 0; i < n; i++) old[8*i +: 8] = mb[base + i];
        sx = old;
        for (int j = 8*n; j < 64; j++) sx[j] = old[8*n-1];
        sum = old + i64;
        for (int i = 0; i < n; i++) mb[base + i] = sum[8*i +: 8];
        res = {1'b0, sx[62:0]};
    endtask

    task automatic fa_now(input string req, input logic [7:0] slot, input int inc,
                          input logic tw, input logic [1:0] sz, input logic [10:0] off);
        logic [63:0] exp;
        model_op(sz, off, inc, exp);
        chk({req, " ready"}, 64'(cmd_ready), 64'd1);
        cmd_word  = mkcmd(slot, inc, tw, sz, off);
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({req, " we"}, 64'(sp_we), 64'd1);
        chk({req, " slot"}, 64'(sp_slot), 64'(slot));
        chk({req, " data"}, sp_data, exp);
    endtask

    task automatic t_reset;
        chk("R1 ready", 64'(cmd_ready), 64'd1);
        chk("R1 we", 64'(sp_we), 64'd0);
        fa_now("R1", 8'h01, 0, 1'b0, 2'd3, 11'd0);
        fa_now("R1", 8'h02, 0, 1'b0, 2'd3, 11'd56);
    endtask

    task automatic t_sizes;
        fa_now("R3", 8'h10, 5, 1'b0, 2'd0, 11'd3);
        fa_now("R3", 8'h11, -2, 1'b0, 2'd1, 11'd8);
        fa_now("R3", 8'h12, 1000, 1'b0, 2'd1, 11'd8);
        fa_now("R3", 8'h13, 2097151, 1'b0, 2'd2, 11'd20);
        fa_now("R3", 8'h14, -1, 1'b0, 2'd3, 11'd24);
        fa_now("R3", 8'h15, -2097152, 1'b0, 2'd3, 11'd24);
        fa_now("R4", 8'h16, 0, 1'b0, 2'd3, 11'd0);
        fa_now("R4", 8'h17, 0, 1'b0, 2'd3, 11'd8);
        fa_now("R4", 8'h18, 0, 1'b0, 2'd3, 11'd16);
    endtask

    task automatic t_wrap;
        fa_now("R3", 8'h20, 127, 1'b0, 2'd0, 11'd7);
        fa_now("R3", 8'h21, 1, 1'b0, 2'd0, 11'd7);
        fa_now("R3", 8'h22, 0, 1'b0, 2'd0, 11'd7);
        fa_now("R4", 8'h23, 0, 1'b0, 2'd3, 11'd0);
    endtask

    task automatic t_alias;
        fa_now("R2", 8'h30, 3, 1'b0, 2'd1, 11'd17);
        fa_now("R2", 8'h31, 0, 1'b0, 2'd3, 11'd16);
        fa_now("R2", 8'h32, 9, 1'b0, 2'd0, 11'd65);
        fa_now("R2", 8'h33, 0, 1'b0, 2'd0, 11'd1);
        fa_now("R2", 8'h34, 4, 1'b0, 2'd2, 11'd1063);
        fa_now("R2", 8'h35, 0, 1'b0, 2'd3, 11'd32);
    endtask

    task automatic t_nopend;
        tsw_pending = 1'b0;
        fa_now("R5", 8'h40, 6, 1'b1, 2'd1, 11'd40);
        fa_now("R5", 8'h41, 0, 1'b1, 2'd1, 11'd40);
    endtask

    task automatic t_wait_done(input int k);
        logic [63:0] exp;
        wait_limit  = 16'd20;
        tsw_pending = 1'b1;
        cmd_word    = mkcmd(8'h50, 77, 1'b1, 2'd2, 11'd44);
        cmd_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6 stall ready", 64'(cmd_ready), 64'd0);
        chk("R6 stall we", 64'(sp_we), 64'd0);
        for (int i = 2; i <= k; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R6 stall ready", 64'(cmd_ready), 64'd0);
            chk("R6 stall we", 64'(sp_we), 64'd0);
        end
        model_op(2'd2, 11'd44, 77, exp);
        tsw_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tsw_done = 1'b0;
        tsw_pending = 1'b0;
        chk("R6 we", 64'(sp_we), 64'd1);
        chk("R6 slot", 64'(sp_slot), 64'h50);
        chk("R6 data", sp_data, exp);
        chk("R6 ready back", 64'(cmd_ready), 64'd1);
        fa_now("R6", 8'h51, 0, 1'b0, 2'd2, 11'd44);
    endtask

    task automatic t_timeout(input int lim);
        wait_limit  = 16'(lim);
        tsw_pending = 1'b1;
        cmd_word    = mkcmd(8'h60, 12, 1'b1, 2'd0, 11'd48);
        cmd_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7 stall we", 64'(sp_we), 64'd0);
        for (int i = 2; i <= lim; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R7 stall we", 64'(sp_we), 64'd0);
            chk("R7 stall ready", 64'(cmd_ready), 64'd0);
        end
        @(posedge clk);
        @(negedge clk);
        tsw_pending = 1'b0;
        chk("R7 we", 64'(sp_we), 64'd1);
        chk("R7 slot", 64'(sp_slot), 64'h60);
        chk("R7 data", sp_data, {1'b1, 63'd0});
        chk("R7 ready back", 64'(cmd_ready), 64'd1);
        fa_now("R7 unchanged", 8'h61, 0, 1'b0, 2'd3, 11'd48);
    endtask

    task automatic t_b2b;
        logic [63:0] exp [3];
        int incs [3] = '{1, 2, 3};
        for (int i = 0; i < 3; i++) model_op(2'd0, 11'd50, incs[i], exp[i]);
        cmd_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cmd_word = mkcmd(8'(8'h70 + i), incs[i], 1'b0, 2'd0, 11'd50);
            @(posedge clk);
            @(negedge clk);
            chk("R8 we", 64'(sp_we), 64'd1);
            chk("R8 slot", 64'(sp_slot), 64'(8'h70 + i));
            chk("R8 data", sp_data, exp[i]);
        end
        cmd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 single write", 64'(sp_we), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMB; i++) mb[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sizes();
        t_wrap();
        t_alias();
        t_nopend();
        t_wait_done(3);
        t_timeout(5);
        t_timeout(0);
        t_b2b();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule